// File: doc/BRIEF.md
# Bus-master DMA descriptor engine

This block moves data for one disk channel between a device byte stream and system memory without processor involvement. Software places a table of 8-byte descriptors in memory, loads the table address into the pointer register, and sets the start bit together with the direction bit. The engine then walks the table. For each descriptor it reads the buffer address and byte count over a simple request/acknowledge memory port. It then moves bytes one at a time, either from the device into memory or from memory out to the device.

The engine stops by itself after the last descriptor is used up. It also stops when software clears the start bit or when a memory access returns an error. The device reports the end of its own transfer on a done input, which raises the interrupt status bit and the interrupt line. Software can tell whether the descriptor table was shorter than, equal to or longer than the device transfer by reading the active and interrupt bits once the channel has settled.

Top module: `bmdma_engine`

## Requirements
- R1: After reset, the command, status and pointer registers read 0, `irq` is low and no memory request is made.
- R2: The register offsets are fixed. Offset 0 is command: bit 0 is start and bit 3 is the direction, where 1 means device to memory. Offset 2 is status: bit 0 is active, bit 1 is error and bit 2 is interrupt. Offset 4 is the 32-bit descriptor-table pointer. Each reads back what was written, except that a pointer write while active is ignored.
- R3: A 0-to-1 change of the start bit sets active and fetches the descriptor at the pointer with two 32-bit reads, at pointer and pointer+4. The descriptor is little-endian: word 0 is the buffer address, word 1 bits 15:0 are the byte count, and word 1 bit 31 set marks the last descriptor. A memory request holds its address until acknowledged.
- R4: The engine treats bit 0 of the byte count as 0, and a count of 0 as 65536 bytes.
- R5: With direction 1, device bytes are written to consecutive addresses from the buffer address. With direction 0, bytes read from consecutive addresses are presented to the device in order.
- R6: When a descriptor that is not the last is used up, the pointer register advances by 8 and the next descriptor is fetched. The pointer is not advanced after the last one.
- R7: When the table covers fewer bytes than the device transfers, active and interrupt both read 0 after the table is used up.
- R8: When the table covers exactly the device transfer, status reads interrupt=1 and active=0.
- R9: When the table covers more bytes than the device transfers, interrupt and active both read 1. Clearing the start bit afterwards leaves interrupt only.
- R10: A device done pulse sets the interrupt bit, and `irq` follows that bit. Writing 1 to status bit 2 clears it.
- R11: A memory error response sets the error bit and clears active. Writing 1 to status bit 1 clears the error bit.
- R12: Clearing the start bit while a transfer is running clears active on the next cycle, and no further memory request is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWe | input | 1 | Host register write strobe |
| regAddr | input | 3 | Host register byte offset |
| regWdata | input | 32 | Host write data |
| regRdata | output | 32 | Host read data for regAddr |
| memReq | output | 1 | Memory request, held until acknowledge or error |
| memWe | output | 1 | Request is a byte write |
| memAddr | output | 32 | Memory address |
| memWdata | output | 8 | Byte to write |
| memRdata | input | 32 | Read data (low byte for buffer reads) |
| memAck | input | 1 | Request completed |
| memErr | input | 1 | Request failed |
| devInValid | input | 1 | Device offers a byte |
| devInData | input | 8 | Byte from the device |
| devInReady | output | 1 | Engine takes the offered byte |
| devOutValid | output | 1 | Engine offers a byte to the device |
| devOutData | output | 8 | Byte to the device |
| devOutReady | input | 1 | Device takes the byte |
| devDone | input | 1 | Device transfer finished (one-cycle pulse) |
| irq | output | 1 | Interrupt line |

## Verification
Several properties are checked on every cycle. A done pulse must be followed by a raised `irq`, and a write-1 to the interrupt bit must drop it. A memory error must leave error set and active clear. A stop write must leave active clear with no memory request. A pending memory request must keep its address and direction, and the pointer may change while active only by a step of 8. Only the bench scenarios can show the rest: the short, equal and longer table outcomes, the count rounding and the 65536 meaning of zero, the byte order in both directions, and the ignored pointer write.

// File: rtl/bmdma_pkg.sv
package bmdma_pkg;
  localparam int OFS_CMD  = 0;
  localparam int OFS_STAT = 2;
  localparam int OFS_PTR  = 4;
  localparam int CMD_START = 0;
  localparam int CMD_TOMEM = 3;
  localparam int ST_ACTIVE = 0;
  localparam int ST_ERR    = 1;
  localparam int ST_INTR   = 2;
  localparam int DESC_LAST = 31;

  typedef enum logic [1:0] {SEL_DESC0, SEL_DESC1, SEL_BUF} addrSel_e;

  typedef struct packed {
    logic     setActive;
    logic     clrActive;
    logic     setErr;
    logic     loadAddr;
    logic     loadCnt;
    logic     stepByte;
    logic     advPtr;
    logic     latchIn;
    logic     latchMem;
    addrSel_e addrSel;
  } dpCtl_t;
endpackage

// File: rtl/bmdma_ctrl.sv
module bmdma_ctrl
  import bmdma_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   startRise,
  input  logic   stopReq,
  input  logic   dirToMem,
  input  logic   lastByte,
  input  logic   lastDesc,
  input  logic   memAck,
  input  logic   memErr,
  input  logic   devInValid,
  input  logic   devOutReady,
  output dpCtl_t ctl,
  output logic   memReq,
  output logic   memWe,
  output logic   devInReady,
  output logic   devOutValid
);
  typedef enum logic [2:0] {S_IDLE, S_DESC0, S_DESC1, S_DEV_IN, S_MEM_WR, S_MEM_RD, S_DEV_OUT} state_e;
  state_e st, nxt;
  logic byteDone;

  always_ff @(posedge clk) begin
    if (!rstN) st <= S_IDLE;
    else       st <= nxt;
  end

  always_comb begin
    ctl = '0;
    ctl.addrSel = SEL_BUF;
    nxt = st;
    memReq = 1'b0;
    memWe = 1'b0;
    devInReady = 1'b0;
    devOutValid = 1'b0;
    byteDone = 1'b0;
    case (st)
      S_IDLE: if (startRise) begin
        ctl.setActive = 1'b1;
        nxt = S_DESC0;
      end
      S_DESC0: begin
        memReq = 1'b1;
        ctl.addrSel = SEL_DESC0;
        if (memAck) begin
          ctl.loadAddr = 1'b1;
          nxt = S_DESC1;
        end
      end
      S_DESC1: begin
        memReq = 1'b1;
        ctl.addrSel = SEL_DESC1;
        if (memAck) begin
          ctl.loadCnt = 1'b1;
          nxt = dirToMem ? S_DEV_IN : S_MEM_RD;
        end
      end
      S_DEV_IN: begin
        devInReady = 1'b1;
        if (devInValid) begin
          ctl.latchIn = 1'b1;
          nxt = S_MEM_WR;
        end
      end
      S_MEM_WR: begin
        memReq = 1'b1;
        memWe = 1'b1;
        byteDone = memAck;
      end
      S_MEM_RD: begin
        memReq = 1'b1;
        if (memAck) begin
          ctl.latchMem = 1'b1;
          nxt = S_DEV_OUT;
        end
      end
      S_DEV_OUT: begin
        devOutValid = 1'b1;
        byteDone = devOutReady;
      end
      default: nxt = S_IDLE;
    endcase

    if (byteDone) begin
      ctl.stepByte = 1'b1;
      if (!lastByte) nxt = dirToMem ? S_DEV_IN : S_MEM_RD;
      else if (lastDesc) begin
        ctl.clrActive = 1'b1;
        nxt = S_IDLE;
      end else begin
        ctl.advPtr = 1'b1;
        nxt = S_DESC0;
      end
    end

    if (memReq && memErr) begin
      ctl = '0;
      ctl.addrSel = SEL_BUF;
      ctl.setErr = 1'b1;
      ctl.clrActive = 1'b1;
      nxt = S_IDLE;
    end

    if (stopReq && st != S_IDLE) begin
      ctl.setErr = 1'b0;
      ctl.clrActive = 1'b1;
      nxt = S_IDLE;
    end
  end
endmodule

// File: rtl/bmdma_datapath.sv
module bmdma_datapath
  import bmdma_pkg::*;
#(
  parameter int AW = 32,
  parameter int CNT_W = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          regWe,
  input  logic [2:0]    regAddr,
  input  logic [31:0]   regWdata,
  output logic [31:0]   regRdata,
  input  dpCtl_t        ctl,
  input  logic [31:0]   memRdata,
  input  logic [7:0]    devInData,
  input  logic          devDone,
  output logic [AW-1:0] memAddr,
  output logic [7:0]    memWdata,
  output logic [7:0]    devOutData,
  output logic          startRise,
  output logic          stopReq,
  output logic          dirToMem,
  output logic          lastByte,
  output logic          lastDesc,
  output logic          active,
  output logic          err,
  output logic          intr,
  output logic [AW-1:0] ptr
);
  localparam int REM_W = CNT_W + 1;

  logic             startBit;
  logic [AW-1:0]    bufAddr;
  logic [REM_W-1:0] remain;
  logic [7:0]       dataByte;
  logic [CNT_W-1:0] rawCnt;
  logic             cmdWr, statWr, ptrWr;

  assign cmdWr  = regWe && (regAddr == 3'(OFS_CMD));
  assign statWr = regWe && (regAddr == 3'(OFS_STAT));
  assign ptrWr  = regWe && (regAddr == 3'(OFS_PTR));
  assign startRise = cmdWr && regWdata[CMD_START] && !startBit;
  assign stopReq   = cmdWr && !regWdata[CMD_START];
  assign rawCnt    = {memRdata[CNT_W-1:1], 1'b0};
  assign lastByte  = (remain == REM_W'(1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      startBit <= 1'b0;
      dirToMem <= 1'b0;
      active   <= 1'b0;
      err      <= 1'b0;
      intr     <= 1'b0;
      ptr      <= '0;
      bufAddr  <= '0;
      remain   <= '0;
      lastDesc <= 1'b0;
      dataByte <= '0;
    end else begin
      if (cmdWr) begin
        startBit <= regWdata[CMD_START];
        if (!active) dirToMem <= regWdata[CMD_TOMEM];
      end
      if (ctl.clrActive)      active <= 1'b0;
      else if (ctl.setActive) active <= 1'b1;
      if (ctl.setErr)                   err <= 1'b1;
      else if (statWr && regWdata[ST_ERR]) err <= 1'b0;
      if (devDone)                        intr <= 1'b1;
      else if (statWr && regWdata[ST_INTR]) intr <= 1'b0;
      if (ptrWr && !active) ptr <= regWdata[AW-1:0];
      else if (ctl.advPtr)  ptr <= ptr + AW'(8);
      if (ctl.loadAddr) bufAddr <= memRdata[AW-1:0];
      else if (ctl.stepByte) bufAddr <= bufAddr + AW'(1);
      if (ctl.loadCnt) begin
        remain   <= (rawCnt == '0) ? {1'b1, {CNT_W{1'b0}}} : {1'b0, rawCnt};
        lastDesc <= memRdata[DESC_LAST];
      end else if (ctl.stepByte) remain <= remain - REM_W'(1);
      if (ctl.latchIn)       dataByte <= devInData;
      else if (ctl.latchMem) dataByte <= memRdata[7:0];
    end
  end

  always_comb begin
    case (ctl.addrSel)
      SEL_DESC0: memAddr = ptr;
      SEL_DESC1: memAddr = ptr + AW'(4);
      default:   memAddr = bufAddr;
    endcase
  end

  assign memWdata   = dataByte;
  assign devOutData = dataByte;

  always_comb begin
    case (regAddr)
      3'(OFS_CMD):  regRdata = {28'd0, dirToMem, 2'd0, startBit};
      3'(OFS_STAT): regRdata = {29'd0, intr, err, active};
      3'(OFS_PTR):  regRdata = 32'(ptr);
      default:      regRdata = '0;
    endcase
  end
endmodule

// File: rtl/bmdma_engine.sv
module bmdma_engine
  import bmdma_pkg::*;
#(
  parameter int AW = 32,
  parameter int CNT_W = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          regWe,
  input  logic [2:0]    regAddr,
  input  logic [31:0]   regWdata,
  output logic [31:0]   regRdata,
  output logic          memReq,
  output logic          memWe,
  output logic [AW-1:0] memAddr,
  output logic [7:0]    memWdata,
  input  logic [31:0]   memRdata,
  input  logic          memAck,
  input  logic          memErr,
  input  logic          devInValid,
  input  logic [7:0]    devInData,
  output logic          devInReady,
  output logic          devOutValid,
  output logic [7:0]    devOutData,
  input  logic          devOutReady,
  input  logic          devDone,
  output logic          irq
);
  dpCtl_t        ctl;
  logic          startRise, stopReq, dirToMem, lastByte, lastDesc;
  logic          dpActive, dpErr, dpIntr;
  logic [AW-1:0] dpPtr;

  bmdma_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .startRise(startRise), .stopReq(stopReq),
    .dirToMem(dirToMem), .lastByte(lastByte), .lastDesc(lastDesc),
    .memAck(memAck), .memErr(memErr), .devInValid(devInValid),
    .devOutReady(devOutReady), .ctl(ctl), .memReq(memReq), .memWe(memWe),
    .devInReady(devInReady), .devOutValid(devOutValid)
  );

  bmdma_datapath #(.AW(AW), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .ctl(ctl), .memRdata(memRdata),
    .devInData(devInData), .devDone(devDone), .memAddr(memAddr),
    .memWdata(memWdata), .devOutData(devOutData), .startRise(startRise),
    .stopReq(stopReq), .dirToMem(dirToMem), .lastByte(lastByte),
    .lastDesc(lastDesc), .active(dpActive), .err(dpErr), .intr(dpIntr),
    .ptr(dpPtr)
  );

  assign irq = dpIntr;
endmodule

// File: rtl/bmdma_engine_chk.sv
module bmdma_engine_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rstN,
  input logic          regWe,
  input logic [2:0]    regAddr,
  input logic          wStart,
  input logic          wIntr,
  input logic          memReq,
  input logic          memWe,
  input logic          memAck,
  input logic          memErr,
  input logic [AW-1:0] memAddr,
  input logic          devDone,
  input logic          irq,
  input logic          active,
  input logic          err,
  input logic [AW-1:0] ptr
);
  logic cmdWr;
  assign cmdWr = regWe && (regAddr == 3'd0);

  // R10: done pulse raises the interrupt line
  a_r10_done_raises_irq: assert property (@(posedge clk) disable iff (!rstN)
    devDone |=> irq);

  // R10: write-1 clears the interrupt
  a_r10_w1c_drops_irq: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && regAddr == 3'd2 && wIntr && !devDone) |=> !irq);

  // R11: error response stops the channel and flags error
  a_r11_err_stops: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memErr && !cmdWr) |=> (err && !active));

  // R12: stop write clears active and withdraws memory traffic
  a_r12_stop_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWr && !wStart) |=> (!active && !memReq));

  // R3: a pending request holds its address and kind
  a_r3_req_held: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck && !memErr && !cmdWr) |=> (memReq && $stable(memAddr) && $stable(memWe)));

  // R6: while active the pointer only moves forward by one descriptor
  a_r6_ptr_step: assert property (@(posedge clk) disable iff (!rstN)
    (active && $past(active) && (ptr != $past(ptr))) |-> (ptr == $past(ptr) + AW'(8)));
endmodule

bind bmdma_engine bmdma_engine_chk #(.AW(AW)) u_chk (
  .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
  .wStart(regWdata[0]), .wIntr(regWdata[2]), .memReq(memReq), .memWe(memWe),
  .memAck(memAck), .memErr(memErr), .memAddr(memAddr), .devDone(devDone),
  .irq(irq), .active(dpActive), .err(dpErr), .ptr(dpPtr)
);

// File: tb/bmdma_engine_bench.sv
`timescale 1ns/1ps
module bmdma_engine_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0;
  logic [2:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        memReq, memWe;
  logic [31:0] memAddr;
  logic [7:0]  memWdata;
  logic [31:0] memRdata = '0;
  logic        memAck = 1'b0, memErr = 1'b0;
  logic        devInValid = 1'b0;
  logic [7:0]  devInData = '0;
  logic        devInReady, devOutValid;
  logic [7:0]  devOutData;
  logic        devOutReady = 1'b0;
  logic        devDone = 1'b0;
  logic        irq;

  int checks = 0;
  int errors = 0;

  // main-owned scenario controls
  logic [31:0] descMem [0:63];
  int devLen = 0;
  int devSeed = 0;
  bit devDirIn = 1'b1;
  int devGo = 0;

  // device-owned / memory-owned state
  logic [7:0] dataMem [0:4095];
  logic [7:0] rxBuf [0:63];
  int devCount = 0;

  bmdma_engine u_bmdma_engine (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .memReq(memReq), .memWe(memWe),
    .memAddr(memAddr), .memWdata(memWdata), .memRdata(memRdata),
    .memAck(memAck), .memErr(memErr), .devInValid(devInValid),
    .devInData(devInData), .devInReady(devInReady), .devOutValid(devOutValid),
    .devOutData(devOutData), .devOutReady(devOutReady), .devDone(devDone),
    .irq(irq)
  );

  initial forever #2.5 clk = ~clk;

  function automatic logic [7:0] devPat(input int seed, input int i);
    return 8'(seed * 37 + i * 11 + 3);
  endfunction

  function automatic logic [7:0] memPat(input logic [31:0] a);
    return a[7:0] ^ 8'h5A;
  endfunction

  function automatic int effCnt(input int c);
    int e;
    e = c & 32'hFFFE;
    return (e == 0) ? 65536 : e;
  endfunction

  function automatic logic [31:0] expStatus(input int cnt, input int len);
    if (cnt < len) return 32'd0;
    if (cnt == len) return 32'd4;
    return 32'd5;
  endfunction

  // memory responder: one-cycle ack, error above 0x7FFF
  initial begin
    forever begin
      @(negedge clk);
      if (memAck || memErr) begin
        memAck = 1'b0;
        memErr = 1'b0;
      end else if (memReq) begin
        if (memAddr[15]) memErr = 1'b1;
        else begin
          memAck = 1'b1;
          if (memWe) dataMem[memAddr[11:0]] = memWdata;
          else if (memAddr < 32'd256) memRdata = descMem[memAddr[7:2]];
          else memRdata = {24'd0, memPat(memAddr)};
        end
      end
    end
  end

  // device model
  initial begin
    int seen = 0;
    bit hsIn = 1'b0, hsOut = 1'b0, doneSent = 1'b0;
    logic [7:0] rxd = '0;
    forever begin
      @(negedge clk);
      devDone = 1'b0;
      if (devGo != seen) begin
        seen = devGo;
        devCount = 0;
        hsIn = 1'b0;
        hsOut = 1'b0;
        doneSent = 1'b0;
      end else begin
        if (hsIn) devCount++;
        if (hsOut) begin
          rxBuf[devCount] = rxd;
          devCount++;
        end
        if (devLen > 0 && devCount == devLen && !doneSent) begin
          devDone = 1'b1;
          doneSent = 1'b1;
        end
      end
      devInValid = devDirIn && (devCount < devLen);
      devInData = devPat(devSeed, devCount);
      devOutReady = !devDirIn && (devCount < devLen);
      hsIn = devInValid && devInReady;
      hsOut = devOutReady && devOutValid;
      rxd = devOutData;
    end
  end

  initial begin
    int cyc = 0;
    while (cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    $display("FAIL watchdog expired: actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks + 1, errors + 1);
    $finish;
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic regWrite(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    regWe = 1'b1;
    regAddr = a;
    regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic regRead(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdata;
  endtask

  task automatic waitCycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setDesc(input int idx, input logic [31:0] addr, input int cnt, input bit last);
    descMem[idx * 2] = addr;
    descMem[idx * 2 + 1] = {last, 15'd0, 16'(cnt)};
  endtask

  task automatic armDevice(input int len, input bit toMem, input int seed);
    devLen = len;
    devDirIn = toMem;
    devSeed = seed;
    devGo++;
    waitCycles(2);
  endtask

  task automatic startEngine(input logic [31:0] p, input bit toMem);
    regWrite(3'd4, p);
    regWrite(3'd0, toMem ? 32'h9 : 32'h1);
  endtask

  task automatic quiesce();
    regWrite(3'd0, 32'h0);
    regWrite(3'd2, 32'h6);
    armDevice(0, 1'b1, 0);
  endtask

  initial begin
    logic [31:0] v;
    void'($urandom(32'd2024));
    for (int i = 0; i < 64; i++) descMem[i] = '0;
    for (int i = 0; i < 4096; i++) dataMem[i] = '0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    regRead(3'd2, v); check("R1 status", v, 0);
    regRead(3'd0, v); check("R1 command", v, 0);
    regRead(3'd4, v); check("R1 pointer", v, 0);
    check("R1 irq", {31'd0, irq}, 0);
    check("R1 memReq", {31'd0, memReq}, 0);

    // R2 register readback
    regWrite(3'd4, 32'h28); regRead(3'd4, v); check("R2 pointer", v, 32'h28);
    regWrite(3'd0, 32'h8);  regRead(3'd0, v); check("R2 dir bit", v, 32'h8);
    regWrite(3'd0, 32'h0);

    // R8/R5/R3 equal length, device to memory
    setDesc(0, 32'h400, 8, 1'b1);
    armDevice(8, 1'b1, 3);
    startEngine(32'd0, 1'b1);
    waitCycles(120);
    regRead(3'd2, v); check("R8 equal status", v, 4);
    check("R10 irq set", {31'd0, irq}, 1);
    for (int i = 0; i < 8; i++) check("R5 tomem byte", {24'd0, dataMem[12'h400 + i]}, {24'd0, devPat(3, i)});
    quiesce();
    regRead(3'd2, v); check("R10 w1c status", v, 0);
    check("R10 irq cleared", {31'd0, irq}, 0);

    // R7 short table
    setDesc(1, 32'h420, 4, 1'b1);
    armDevice(8, 1'b1, 4);
    startEngine(32'd8, 1'b1);
    waitCycles(120);
    regRead(3'd2, v); check("R7 short status", v, 0);
    check("R7 bytes taken", devCount, 4);
    quiesce();

    // R9 long table, R2 pointer write ignored while active
    setDesc(2, 32'h440, 16, 1'b1);
    armDevice(6, 1'b1, 5);
    startEngine(32'd16, 1'b1);
    waitCycles(100);
    regRead(3'd2, v); check("R9 long status", v, 5);
    regWrite(3'd4, 32'h99);
    regRead(3'd4, v); check("R2 pointer frozen", v, 16);
    regWrite(3'd0, 32'h0);
    regRead(3'd2, v); check("R9 after stop", v, 4);
    quiesce();

    // R4 zero count means 65536
    setDesc(3, 32'h800, 0, 1'b1);
    armDevice(20, 1'b1, 6);
    startEngine(32'd24, 1'b1);
    waitCycles(200);
    regRead(3'd2, v); check("R4 zero count", v, 5);
    quiesce();

    // R4 odd count rounds down
    setDesc(4, 32'h460, 5, 1'b1);
    armDevice(4, 1'b1, 7);
    startEngine(32'd32, 1'b1);
    waitCycles(100);
    regRead(3'd2, v); check("R4 odd count", v, 4);
    quiesce();

    // R6 two descriptors
    setDesc(5, 32'h500, 6, 1'b0);
    setDesc(6, 32'h600, 4, 1'b1);
    armDevice(10, 1'b1, 8);
    startEngine(32'd40, 1'b1);
    waitCycles(160);
    regRead(3'd2, v); check("R6 chain status", v, 4);
    regRead(3'd4, v); check("R6 pointer advanced", v, 48);
    for (int i = 0; i < 6; i++) check("R6 first buffer", {24'd0, dataMem[12'h500 + i]}, {24'd0, devPat(8, i)});
    for (int i = 0; i < 4; i++) check("R6 second buffer", {24'd0, dataMem[12'h600 + i]}, {24'd0, devPat(8, 6 + i)});
    quiesce();

    // R5 memory to device
    setDesc(7, 32'h700, 6, 1'b1);
    armDevice(6, 1'b0, 9);
    startEngine(32'd56, 1'b0);
    waitCycles(120);
    regRead(3'd2, v); check("R5 frommem status", v, 4);
    for (int i = 0; i < 6; i++) check("R5 frommem byte", {24'd0, rxBuf[i]}, {24'd0, memPat(32'h700 + 32'(i))});
    quiesce();

    // R11 memory error
    setDesc(8, 32'hF000, 8, 1'b1);
    armDevice(4, 1'b1, 10);
    startEngine(32'd64, 1'b1);
    waitCycles(60);
    regRead(3'd2, v); check("R11 error status", v, 2);
    regWrite(3'd2, 32'h2);
    regRead(3'd2, v); check("R11 error cleared", v, 0);
    quiesce();

    // R12 stop mid-transfer
    setDesc(9, 32'h880, 32, 1'b1);
    armDevice(32, 1'b1, 11);
    startEngine(32'd72, 1'b1);
    waitCycles(15);
    regWrite(3'd0, 32'h0);
    regRead(3'd2, v); check("R12 stopped status", v, 0);
    begin
      int reqs = 0;
      for (int i = 0; i < 40; i++) begin
        @(negedge clk);
        if (memReq) reqs++;
      end
      check("R12 no requests", reqs, 0);
    end
    quiesce();

    // random mix: R5 R7 R8 R9
    for (int it = 0; it < 12; it++) begin
      int cnt, len, n;
      bit toMem;
      cnt = 2 * ($urandom % 20 + 1);
      len = $urandom % 40 + 1;
      toMem = 1'($urandom % 2);
      n = (cnt < len) ? cnt : len;
      setDesc(10, 32'h900, cnt, 1'b1);
      armDevice(len, toMem, 20 + it);
      startEngine(32'd80, toMem);
      waitCycles((cnt + len) * 8 + 60);
      regRead(3'd2, v);
      check("R7/R8/R9 random status", v, expStatus(effCnt(cnt), len));
      check("R5 random byte count", devCount, n);
      for (int i = 0; i < n; i++) begin
        if (toMem) check("R5 random tomem", {24'd0, dataMem[12'h900 + i]}, {24'd0, devPat(20 + it, i)});
        else check("R5 random frommem", {24'd0, rxBuf[i]}, {24'd0, memPat(32'h900 + 32'(i))});
      end
      quiesce();
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule